// File: doc/BRIEF.md
# Synchronized Clock-Enable Divider Bank

This block derives a set of periodic clock-enable strobes from a single base clock. Each of sixteen system outputs has its own integer divider. A seventeenth bypass divider advances only on reference ticks, which arrive as single-cycle pulses in the base clock domain. Every output is a one-cycle enable pulse, never a gated clock, so all downstream logic stays on the base clock.

Software writes new divide ratios through a small register port. A write only stages a ratio. Nothing takes effect until a GO command starts a transition, and a status bit stays high while that transition is under way. An output that is not marked for alignment switches at its own next terminal count, so no period is ever cut short. Outputs marked in the align mask stop at their terminal count. Once every one of them has stopped, they all load their new ratios and restart from zero in the same cycle, which makes their strobes coincide from then on. A wake mask silences individual strobes without disturbing their counters.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, each output divides by 1 (it pulses every base cycle, or on every reference tick for the bypass output). A divider register reads 0x8000. The status register at address 18 reads 0, the align register at address 19 reads 0, and the wake register at address 20 reads 0xFFFF.
- R2: Addresses 0 to 15 hold the system dividers. Bit 15 is the enable and bits 4:0 are the ratio field; on read-back all other bits are 0. With the enable set, the output pulses once every ratio+1 cycles. With the enable clear, the output divides by 1 whatever the ratio field holds.
- R3: A write to a divider register changes nothing at the outputs until a GO command is issued.
- R4: A GO command is a 0-to-1 change of bit 0 of the command register at address 17. Writing 1 while that bit already holds 1 does not start a transition.
- R5: Bit 0 of the status register reads 1 from the GO until every output has taken its staged value. A GO issued while this bit is 1 is ignored.
- R6: An output that is not selected for alignment loads its staged ratio only at its own terminal count. Every interval between its pulses is therefore either the full old period or the full new period.
- R7: Bit i of the align register at address 19 selects system output i. Each selected output stops at its terminal count. When all selected outputs have stopped, they load their staged ratios and restart from zero in the same cycle, so their strobes coincide afterwards.
- R8: A clear bit i in the wake register at address 20 suppresses the pulses of system output i and keeps its divider setting. Setting the bit again restores the pulses at the programmed rate.
- R9: A divider register reads back its applied value while status bit 0 is 0, and its staged value while status bit 0 is 1.
- R10: The bypass divider sits at address 16 and uses the same format as the system dividers. It counts reference ticks rather than base cycles and takes a staged ratio through the same GO sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 5 | Register read address |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| rd_data_o | output | 16 | Registered read data |
| clk_en_o | output | 16 | System clock-enable pulses |
| bp_en_o | output | 1 | Bypass clock-enable pulse |

## Verification
Two things can land in the same transition window: a second GO, and staged-register writes aimed at outputs that have already switched. The bench freezes the reference ticks so that the bypass divider cannot reach terminal count, which holds the busy bit high for as long as needed. During that window it restages an output that has already switched and issues a fresh GO. It then confirms that the restaged ratio never reaches the output and never appears as the applied value. A second collision is between one output's own terminal-count load and the common restart of the aligned outputs. It is judged by pulse spacing on a non-aligned output and by cycle-exact coincidence of the aligned strobes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DATA_W  = 16;
  localparam int RATIO_W = 5;
  localparam int EN_BIT  = 15;

  typedef struct packed {
    logic               en;
    logic [RATIO_W-1:0] ratio;
  } div_cfg_t;

  localparam div_cfg_t CFG_RESET = '{en: 1'b1, ratio: '0};

  function automatic logic [DATA_W-1:0] cfg_to_word(input div_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT] = c.en;
    w[RATIO_W-1:0] = c.ratio;
    return w;
  endfunction

  function automatic logic [RATIO_W-1:0] last_count(input div_cfg_t c);
    return c.en ? c.ratio : '0;
  endfunction
endpackage

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick_i,
  input  logic     wake_i,
  input  logic     aligned_i,
  input  logic     pend_i,
  input  logic     sync_load_i,
  input  div_cfg_t staged_i,
  output logic     pulse_o,
  output logic     load_done_o,
  output logic     parked_o,
  output div_cfg_t active_o
);
  logic [RATIO_W-1:0] cnt_q;
  div_cfg_t           act_q;
  logic               parked_q;
  logic               pulse_q;
  logic               term;
  logic               own_load;
  logic               park_now;

  assign term     = (cnt_q == last_count(act_q));
  assign own_load = tick_i && !parked_q && term && pend_i && !aligned_i;
  assign park_now = tick_i && !parked_q && term && pend_i && aligned_i;

  assign load_done_o = own_load || (sync_load_i && parked_q);
  assign parked_o    = parked_q;
  assign pulse_o     = pulse_q;
  assign active_o    = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      act_q    <= CFG_RESET;
      parked_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= tick_i && term && !parked_q && wake_i;
      if (sync_load_i && parked_q) begin
        act_q    <= staged_i;
        cnt_q    <= '0;
        parked_q <= 1'b0;
      end else if (tick_i && !parked_q) begin
        if (own_load) begin
          act_q <= staged_i;
          cnt_q <= '0;
        end else if (park_now) begin
          parked_q <= 1'b1;
        end else if (term) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_count(act_q));

  p_switch_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> (cnt_q == '0));

  p_pulse_needs_wake_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(wake_i));
endmodule

// File: rtl/clkdiv_align.sv
module clkdiv_align #(
  parameter int LANES = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] mask_i,
  input  logic [LANES-1:0] pend_i,
  input  logic [LANES-1:0] parked_i,
  output logic             sync_o
);
  logic [LANES-1:0] waiting;

  assign waiting = mask_i & pend_i;
  assign sync_o  = (|waiting) && ((waiting & ~parked_i) == '0);

  p_sync_releases_r7: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> ((parked_i & mask_i) == '0));

  p_park_only_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (|parked_i) |-> ((parked_i & ~pend_i) == '0));
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int N_OUT  = 16,
  parameter int ADDR_W = 5,
  parameter int LANES  = N_OUT + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic                    rd_valid_o,
  output logic [DATA_W-1:0]       rd_data_o,
  input  div_cfg_t [LANES-1:0]    active_i,
  input  logic [LANES-1:0]        load_done_i,
  output div_cfg_t [LANES-1:0]    staged_o,
  output logic [LANES-1:0]        pend_o,
  output logic [LANES-1:0]        align_mask_o,
  output logic [N_OUT-1:0]        wake_o
);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(N_OUT + 1);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(N_OUT + 2);
  localparam logic [ADDR_W-1:0] A_ALIGN  = ADDR_W'(N_OUT + 3);
  localparam logic [ADDR_W-1:0] A_WAKE   = ADDR_W'(N_OUT + 4);

  div_cfg_t [LANES-1:0] staged_q;
  logic [LANES-1:0]     pend_q;
  logic [N_OUT-1:0]     align_q;
  logic [N_OUT-1:0]     align_lat_q;
  logic [N_OUT-1:0]     wake_q;
  logic                 cmd_q;
  logic                 busy_q;
  logic                 go_fire;
  logic [DATA_W-1:0]    rd_mux;

  assign go_fire = wr_en_i && (wr_addr_i == A_CMD) && wr_data_i[0] && !cmd_q && !busy_q;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rd_addr_i == ADDR_W'(i))
        rd_mux = cfg_to_word(busy_q ? staged_q[i] : active_i[i]);
    end
    if (rd_addr_i == A_CMD)    rd_mux = DATA_W'(cmd_q);
    if (rd_addr_i == A_STATUS) rd_mux = DATA_W'(busy_q);
    if (rd_addr_i == A_ALIGN)  rd_mux = DATA_W'(align_q);
    if (rd_addr_i == A_WAKE)   rd_mux = DATA_W'(wake_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) staged_q[i] <= CFG_RESET;
      pend_q      <= '0;
      align_q     <= '0;
      align_lat_q <= '0;
      wake_q      <= '1;
      cmd_q       <= 1'b0;
      busy_q      <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      if (wr_en_i) begin
        for (int i = 0; i < LANES; i++) begin
          if (wr_addr_i == ADDR_W'(i)) begin
            staged_q[i].en    <= wr_data_i[EN_BIT];
            staged_q[i].ratio <= wr_data_i[RATIO_W-1:0];
          end
        end
        if (wr_addr_i == A_CMD)   cmd_q   <= wr_data_i[0];
        if (wr_addr_i == A_ALIGN) align_q <= wr_data_i[N_OUT-1:0];
        if (wr_addr_i == A_WAKE)  wake_q  <= wr_data_i[N_OUT-1:0];
      end
      if (go_fire) begin
        pend_q      <= '1;
        align_lat_q <= align_q;
        busy_q      <= 1'b1;
      end else begin
        pend_q <= pend_q & ~load_done_i;
        if (busy_q && (pend_q == '0)) busy_q <= 1'b0;
      end
      rd_valid_o <= rd_en_i;
      rd_data_o  <= rd_mux;
    end
  end

  assign staged_o     = staged_q;
  assign pend_o       = pend_q;
  assign align_mask_o = {{(LANES-N_OUT){1'b0}}, align_lat_q};
  assign wake_o       = wake_q;

  p_pend_implies_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (|pend_q) |-> busy_q);

  p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(pend_q) == '0));

  p_staged_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(staged_q));
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int N_OUT  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [15:0]       rd_data_o,
  output logic [N_OUT-1:0]  clk_en_o,
  output logic              bp_en_o
);
  localparam int LANES = N_OUT + 1;
  localparam int BP    = N_OUT;

  div_cfg_t [LANES-1:0] staged;
  div_cfg_t [LANES-1:0] active;
  logic [LANES-1:0]     pend;
  logic [LANES-1:0]     align_mask;
  logic [LANES-1:0]     load_done;
  logic [LANES-1:0]     parked;
  logic [LANES-1:0]     pulses;
  logic [N_OUT-1:0]     wake;
  logic                 sync_load;

  clkdiv_regs #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .LANES(LANES)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .active_i(active), .load_done_i(load_done),
    .staged_o(staged), .pend_o(pend), .align_mask_o(align_mask), .wake_o(wake)
  );

  clkdiv_align #(.LANES(LANES)) align_i (
    .clk(clk), .rst(rst),
    .mask_i(align_mask), .pend_i(pend), .parked_i(parked),
    .sync_o(sync_load)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic tick;
    logic wake_bit;
    if (g == BP) begin : g_bypass
      assign tick     = ref_tick_i;
      assign wake_bit = 1'b1;
    end else begin : g_sys
      assign tick     = 1'b1;
      assign wake_bit = wake[g];
    end
    clkdiv_lane lane_i (
      .clk(clk), .rst(rst),
      .tick_i(tick), .wake_i(wake_bit),
      .aligned_i(align_mask[g]), .pend_i(pend[g]),
      .sync_load_i(sync_load), .staged_i(staged[g]),
      .pulse_o(pulses[g]), .load_done_o(load_done[g]),
      .parked_o(parked[g]), .active_o(active[g])
    );
  end

  assign clk_en_o = pulses[N_OUT-1:0];
  assign bp_en_o  = pulses[BP];
endmodule

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [15:0] clk_en;
  logic        bp_en;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit ref_run = 1'b1;
  logic [15:0] last_rd = '0;

  logic [15:0] exp_q[$];
  bit          chk_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  clkdiv_bank dut_i (
    .clk(clk), .rst(rst), .ref_tick_i(ref_tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .clk_en_o(clk_en), .bp_en_o(bp_en)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    ref_tick = ref_run && (cyc % 4 == 0);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "read with no expected item", int'(rd_data), -1);
      end else begin
        logic [15:0] e;
        bit c;
        string t;
        e = exp_q.pop_front();
        c = chk_q.pop_front();
        t = tag_q.pop_front();
        last_rd = rd_data;
        if (c) check(rd_data == e, t, int'(rd_data), int'(e));
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_push(input logic [4:0] a, input logic [15:0] e, input bit c, input string t);
    exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [15:0] e, input string t);
    rd_push(a, e, 1'b1, t);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      rd_push(5'd18, 16'h0, 1'b0, "poll");
      if (last_rd[0] == 1'b0) return;
    end
    check(1'b0, "busy never cleared", 1, 0);
  endtask

  task automatic count(input int idx, input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hits += (idx == 16) ? int'(bp_en) : int'(clk_en[idx]);
    end
  endtask

  task automatic go();
    wr(5'd17, 16'h0);
    wr(5'd17, 16'h1);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int n7;
    int mism;
    int last;
    int bad;
    bit seen2;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_exp(5'd0, 16'h8000, "R1 div0 reset");
    rd_exp(5'd16, 16'h8000, "R1 bypass reset");
    rd_exp(5'd18, 16'h0000, "R1 status reset");
    rd_exp(5'd19, 16'h0000, "R1 align reset");
    rd_exp(5'd20, 16'hFFFF, "R1 wake reset");
    count(3, 20, n); check(n == 20, "R1 out3 divide-by-1", n, 20);
    count(16, 40, n); check(n == 10, "R1 R10 bypass follows ticks", n, 10);

    // R3 staging only
    wr(5'd0, 16'h8003);
    wr(5'd3, 16'h0005);
    wr(5'd4, 16'h8002);
    count(0, 20, n); check(n == 20, "R3 staged ratio not applied", n, 20);
    rd_exp(5'd0, 16'h8000, "R9 idle readback is applied value");

    // R2 ratios after GO
    wr(5'd17, 16'h1);
    wait_idle();
    count(0, 20, n); check(n == 5, "R2 divide by 4", n, 5);
    count(3, 12, n); check(n == 12, "R2 enable clear gives divide by 1", n, 12);
    count(4, 12, n); check(n == 4, "R2 divide by 3", n, 4);
    rd_exp(5'd3, 16'h0005, "R2 readback enable clear");

    // R8 wake mask
    wr(5'd20, 16'hFFEF);
    count(4, 12, n); check(n == 0, "R8 silenced output", n, 0);
    rd_exp(5'd4, 16'h8002, "R8 setting kept");
    wr(5'd20, 16'hFFFF);
    count(4, 12, n); check(n == 4, "R8 resumed rate", n, 4);

    // R5 / R9 busy window held by frozen reference ticks
    ref_run = 1'b0;
    wr(5'd16, 16'h8001);
    go();
    rd_exp(5'd18, 16'h0001, "R5 busy during transition");
    rd_exp(5'd16, 16'h8001, "R9 staged value while busy");
    wr(5'd2, 16'h8007);
    go();
    ref_run = 1'b1;
    wait_idle();
    rd_exp(5'd2, 16'h8000, "R5 GO while busy ignored");
    count(2, 16, n); check(n == 16, "R5 out2 unchanged", n, 16);
    count(16, 80, n); check(n == 10, "R10 bypass divide by 2", n, 10);

    // R4 repeated 1 is no command
    wr(5'd17, 16'h1);
    rd_exp(5'd18, 16'h0000, "R4 no transition without 0-to-1");
    count(2, 16, n); check(n == 16, "R4 out2 still divide by 1", n, 16);
    go();
    wait_idle();
    count(2, 16, n); check(n == 2, "R4 fresh GO applies divide by 8", n, 2);

    // R6 no shortened period
    wr(5'd5, 16'h8003);
    go();
    wait_idle();
    wr(5'd5, 16'h8001);
    wr(5'd17, 16'h0);
    last = -1; bad = 0; seen2 = 1'b0;
    fork
      wr(5'd17, 16'h1);
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (clk_en[5]) begin
          if (last >= 0) begin
            if ((c - last) != 4 && (c - last) != 2) bad++;
            if (seen2 && (c - last) == 4) bad++;
            if ((c - last) == 2) seen2 = 1'b1;
          end
          last = c;
        end
      end
    join
    check(bad == 0, "R6 intervals only old or new period", bad, 0);
    check(seen2, "R6 new period reached", int'(seen2), 1);
    wait_idle();

    // R7 aligned restart
    wr(5'd6, 16'h8002);
    wr(5'd7, 16'h8004);
    go();
    wait_idle();
    wr(5'd19, 16'h00C0);
    rd_exp(5'd19, 16'h00C0, "R7 align mask readback");
    wr(5'd6, 16'h8003);
    wr(5'd7, 16'h8003);
    go();
    wait_idle();
    n = 0; n7 = 0; mism = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      n += int'(clk_en[6]);
      n7 += int'(clk_en[7]);
      if (clk_en[6] != clk_en[7]) mism++;
    end
    check(mism == 0, "R7 aligned strobes coincide", mism, 0);
    check(n == 10, "R7 out6 divide by 4", n, 10);
    check(n7 == 10, "R7 out7 divide by 4", n7, 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule